// File: doc/BRIEF.md
# Packet Receiver with Tag Acknowledgment

This block sits at the receiving end of a point-to-point channel. Each clock cycle it may take in one 32-bit packet. The top byte is a header and the lower three bytes are the body. The two most significant header bits give the packet kind, and the six bits below them carry a tag. Data and control packets go to a downstream port with a kind indication. For each of them the block returns a 7-bit acknowledgment with a valid strobe, which echoes the tag back to the sender.

Void packets are dropped without any trace. A header kind that is not defined is treated as malformed: the packet is dropped and a protocol-error pulse is raised. A data packet that carries the same tag as the last accepted data packet raises a duplicate flag. That packet is still delivered and acknowledged, so a sender that repeats a packet after losing its acknowledgment can finish the exchange. Commands inside control packets are not interpreted.

Top module: `pkt_ack_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, ack_valid, out_valid, proto_err and dup_flag are all low.
- R2: A packet whose header kind in_pkt[31:30] is 2'b10 (data) is delivered one cycle after it is sampled: out_valid=1, out_is_ctrl=0, out_tag=in_pkt[29:24], out_body=in_pkt[23:0].
- R3: A packet whose header kind is 2'b01 (control) is delivered one cycle later with out_is_ctrl=1, out_tag=0 and the body passed through unchanged.
- R4: Every accepted data or control packet produces exactly one ack_valid pulse. The pulse is one cycle wide and comes in the cycle after in_valid is sampled. ack_valid is never high unless in_valid was high in the cycle before.
- R5: The acknowledgment code has bit 6 set and the packet's tag in bits [5:0]. A control packet is always acknowledged as 7'b1000000.
- R6: A void packet (kind 2'b00) gives no ack_valid, no out_valid, no proto_err and no dup_flag, whatever its tag and body.
- R7: A packet of kind 2'b11 is dropped. It gives no ack_valid and no out_valid, and it raises proto_err for one cycle, one cycle after it is sampled.
- R8: A control packet with a nonzero tag field raises proto_err one cycle later. It is still delivered and acknowledged with code 7'b1000000.
- R9: A data packet whose tag equals the tag of the last accepted data packet raises dup_flag in the same cycle as its acknowledgment, and it is still acknowledged and delivered. The first data packet after reset never raises dup_flag.
- R10: Only accepted data packets change the remembered tag. Void, malformed and control packets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet present on in_pkt |
| in_pkt | input | 32 | Header [31:24] (kind [31:30], tag [29:24]) and body [23:0] |
| out_valid | output | 1 | Delivered packet strobe |
| out_is_ctrl | output | 1 | 1 for control, 0 for data |
| out_tag | output | 6 | Tag of delivered packet (0 for control) |
| out_body | output | 24 | Body of delivered packet |
| ack_valid | output | 1 | Acknowledgment strobe |
| ack_code | output | 7 | Acknowledgment: 1 followed by 6-bit tag |
| proto_err | output | 1 | Malformed-kind or bad control tag pulse |
| dup_flag | output | 1 | Data tag repeats the last accepted data tag |

## Verification
The hardest case to reach is a duplicate that spans packets which must not count: a data tag, then a void, malformed or control packet, then the same data tag again. Only that pattern shows whether the remembered tag is kept across non-data traffic. The stimulus places each kind of interloper between two data packets with equal tags. It also sends such sequences back to back with no idle cycles, so that a tag update in the wrong cycle shows up as a missing or extra dup_flag. A pass over varied kinds and tags then compares every cycle's outputs against a model built from the requirements.

// File: rtl/pkt_ack_rx.sv
module pkt_ack_rx #(
  parameter int TAG_W  = 6,
  parameter int BODY_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [TAG_W+BODY_W+1:0] in_pkt,
  output logic                 out_valid,
  output logic                 out_is_ctrl,
  output logic [TAG_W-1:0]     out_tag,
  output logic [BODY_W-1:0]    out_body,
  output logic                 ack_valid,
  output logic [TAG_W:0]       ack_code,
  output logic                 proto_err,
  output logic                 dup_flag
);
  localparam int HDR_W = TAG_W + 2;
  localparam int PKT_W = HDR_W + BODY_W;

  typedef enum logic [1:0] {K_VOID = 2'b00, K_CTRL = 2'b01, K_DATA = 2'b10, K_BAD = 2'b11} kind_e;

  kind_e               kind_in;
  logic [TAG_W-1:0]    tag_in;
  logic [BODY_W-1:0]   body_in;
  logic                is_data, is_ctrl, is_bad, accept;
  logic                seen_q;
  logic [TAG_W-1:0]    last_tag_q;

  assign kind_in = kind_e'(in_pkt[PKT_W-1 -: 2]);
  assign tag_in  = in_pkt[PKT_W-3 -: TAG_W];
  assign body_in = in_pkt[BODY_W-1:0];
  assign is_data = in_valid && kind_in == K_DATA;
  assign is_ctrl = in_valid && kind_in == K_CTRL;
  assign is_bad  = in_valid && kind_in == K_BAD;
  assign accept  = is_data || is_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_ctrl <= 1'b0;
      out_tag     <= '0;
      out_body    <= '0;
      ack_valid   <= 1'b0;
      ack_code    <= '0;
      proto_err   <= 1'b0;
      dup_flag    <= 1'b0;
      seen_q      <= 1'b0;
      last_tag_q  <= '0;
    end else begin
      out_valid <= accept;
      ack_valid <= accept;
      proto_err <= is_bad || (is_ctrl && tag_in != '0);
      dup_flag  <= is_data && seen_q && tag_in == last_tag_q;
      if (accept) begin
        out_is_ctrl <= is_ctrl;
        out_tag     <= is_ctrl ? '0 : tag_in;
        out_body    <= body_in;
        ack_code    <= {1'b1, (is_ctrl ? {TAG_W{1'b0}} : tag_in)};
      end
      if (is_data) begin
        seen_q     <= 1'b1;
        last_tag_q <= tag_in;
      end
    end
  end

  a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_pkt[PKT_W-1 -: 2] == 2'b10 || in_pkt[PKT_W-1 -: 2] == 2'b01)) |=> ack_valid);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(in_valid));
  a_r5_ack_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_code[TAG_W]);
  a_r3_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_ctrl) |-> (ack_code == {1'b1, {TAG_W{1'b0}}} && out_tag == '0));
  a_r6_void_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pkt[PKT_W-1 -: 2] == 2'b00) |=> (!ack_valid && !out_valid && !proto_err && !dup_flag));
  a_r7_bad_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pkt[PKT_W-1 -: 2] == 2'b11) |=> (proto_err && !ack_valid && !out_valid));
  a_r9_dup_acked: assert property (@(posedge clk) disable iff (!rst_n)
    dup_flag |-> (ack_valid && !out_is_ctrl));
endmodule

// File: tb/pkt_ack_rx_tb.sv
module pkt_ack_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pkt = '0;
  logic        out_valid, out_is_ctrl, ack_valid, proto_err, dup_flag;
  logic [5:0]  out_tag;
  logic [23:0] out_body;
  logic [6:0]  ack_code;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic        ov;
    logic        ctrl;
    logic [5:0]  tag;
    logic [23:0] body;
    logic        av;
    logic [6:0]  code;
    logic        err;
    logic        dup;
  } exp_t;

  exp_t        q[$];
  string       rq[$];
  logic        m_seen = 1'b0;
  logic [5:0]  m_last = '0;

  always #5 clk = ~clk;

  pkt_ack_rx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_is_ctrl(out_is_ctrl), .out_tag(out_tag),
    .out_body(out_body), .ack_valid(ack_valid), .ack_code(ack_code),
    .proto_err(proto_err), .dup_flag(dup_flag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [1:0] k, input logic [5:0] t, input logic [23:0] b);
    exp_t  e;
    string r;
    @(negedge clk);
    in_valid = v;
    in_pkt   = {k, t, b};
    e = '0;
    r = "R4 idle";
    if (v && (k == 2'b10 || k == 2'b01)) begin
      e.ov   = 1'b1;
      e.av   = 1'b1;
      e.body = b;
      e.ctrl = (k == 2'b01);
      e.tag  = e.ctrl ? 6'd0 : t;
      e.code = {1'b1, e.tag};
      e.err  = e.ctrl && t != 0;
      e.dup  = !e.ctrl && m_seen && t == m_last;
      if (!e.ctrl) begin
        m_seen = 1'b1;
        m_last = t;
        r = e.dup ? "R9 dup data" : "R2/R5 data";
      end else begin
        r = e.err ? "R8 ctrl bad tag" : "R3/R5 ctrl";
      end
    end else if (v && k == 2'b11) begin
      e.err = 1'b1;
      r = "R7 malformed";
    end else if (v) begin
      r = "R6/R10 void";
    end
    q.push_back(e);
    rq.push_back(r);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t  e;
      string r;
      e = q.pop_front();
      r = rq.pop_front();
      chk({r, " valids"}, {60'd0, out_valid, ack_valid, proto_err, dup_flag},
          {60'd0, e.ov, e.av, e.err, e.dup});
      if (e.ov) chk({r, " payload"}, {26'd0, out_is_ctrl, out_tag, out_body, ack_code},
                    {26'd0, e.ctrl, e.tag, e.body, e.code});
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, out_valid, ack_valid, proto_err, dup_flag}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 first cycle after reset", {60'd0, out_valid, ack_valid, proto_err, dup_flag}, 64'd0);
    send(1, 2'b10, 6'd5,  24'hABCDEF);
    send(1, 2'b10, 6'd5,  24'h123456);
    send(1, 2'b10, 6'd6,  24'h000001);
    send(1, 2'b00, 6'd6,  24'hFFFFFF);
    send(1, 2'b10, 6'd6,  24'h000002);
    send(1, 2'b01, 6'd0,  24'hC0FFEE);
    send(1, 2'b01, 6'd9,  24'hBEEF00);
    send(1, 2'b11, 6'd6,  24'h777777);
    send(1, 2'b10, 6'd6,  24'h000003);
    send(0, 2'b10, 6'd7,  24'h000004);
    send(1, 2'b10, 6'h3F, 24'h800000);
    send(1, 2'b10, 6'h00, 24'h000000);
    send(1, 2'b00, 6'h00, 24'h000000);
    send(1, 2'b10, 6'h00, 24'h555555);
    send(0, 2'b00, 6'h00, 24'h0);
    for (int i = 0; i < 40; i++) begin
      send(i % 7 != 3, 2'((i * 5 + 1) % 4), 6'((i * 3) % 5), 24'(i * 32'h010203));
    end
    send(0, 2'b00, 6'h00, 24'h0);
    send(0, 2'b00, 6'h00, 24'h0);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule